// File: doc/BRIEF.md
# Single-Pass Multi-Configuration Cache Analyzer

This block takes a stream of memory addresses, one per handshake, and decides for a whole family of cache shapes at once whether each access would have hit or missed. It does not model tag arrays. It keeps one recency stack of distinct block addresses, with the most recently used block at position 0. For each access it walks the stack from the top. Along the way it counts the blocks that share the current block's set under each candidate set count. The result is one hit or miss verdict per configuration.

The configurations cover set counts of 2^s for s = 0..K and associativities of 1, 2 and 4. Every configuration has its own hit counter and miss counter, read through a select port. A synchronous clear empties the stack and zeroes all counters, so a new trace can start. The walk handles one stack entry per cycle, and the input handshake holds off the next address until the stack has been rewritten.

Top module: `sspa_analyzer`

## Requirements
- R1: The block address is `in_addr` shifted right by OFF_W (default 2). Accesses that differ only in the low OFF_W bits refer to the same block.
- R2: An access whose block is not in the stack is compulsory: `res_compulsory` = 1 and every bit of `res_hit` is 0.
- R3: For a block found at stack position p, the conflict count for set exponent s is the number of entries at positions 0..p-1 whose low s block-address bits equal those of the current block. The count saturates at 4.
- R4: Configuration index c = s*3 + a has set count 2^s and associativity 2^a. `res_hit[c]` is 1 exactly when the block was found and its conflict count for s is below 2^a.
- R5: After each access the block sits at position 0, with any older copy removed. An immediate repeat of a block therefore hits in every configuration.
- R6: A new block arriving while DEPTH (default 16) blocks are stored discards the bottom entry and reports `res_dropped` = 1. The discarded block is compulsory when it is accessed again.
- R7: `in_ready` is low from the accepting edge until the result. `res_valid` is a one-cycle pulse that arrives p+2 cycles after acceptance for a block found at position p, or n+2 cycles after acceptance for a new block with n blocks stored. `in_ready` is high in the cycle after `res_valid`.
- R8: Each result adds one to exactly one counter per configuration: the hit counter if `res_hit[c]` is 1, otherwise the miss counter. `rd_sel` = c shows that configuration's counters on `rd_hits` and `rd_misses`, and the counters are already updated when `res_valid` is seen.
- R9: A cycle with `clr` high zeroes all counters, empties the stack and returns the block to ready. A block seen before the clear is compulsory afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of stack and counters |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Block is idle and accepts an address |
| in_addr | input | ADDR_W | Byte address of the access |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | NCFG | Hit flag per configuration, index s*3+a |
| res_compulsory | output | 1 | Block was not in the stack |
| res_dropped | output | 1 | Bottom stack entry was discarded |
| rd_sel | input | SW | Configuration whose counters are shown |
| rd_hits | output | CNT_W | Hit counter of the selected configuration |
| rd_misses | output | CNT_W | Miss counter of the selected configuration |

## Verification
A wrong stack order or a lost entry does not show up at once. It appears only when a later access reaches the damaged region. It then shows as a wrong `res_hit` pattern or `res_compulsory` flag, and also as a wrong latency, because the result time reveals the position where the block was found. A conflict counter that mis-counts or fails to saturate changes the hit vector within the same access. A counter fault becomes visible on the read port in the cycle that `res_valid` rises. The bench keeps its own list model of the stack and compares every result, and every result's timing, against that model.

// File: rtl/sspa_pkg.sv
package sspa_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_UPDATE} st_t;

  // associativities 1, 2, 4 -> index a gives 2^a ways
  localparam int NUM_ASSOC = 3;
  localparam int CONF_SAT  = 1 << (NUM_ASSOC - 1);
  localparam int CONF_W    = $clog2(CONF_SAT + 1);

  // true when the low 'bits' bits of x and y agree
  function automatic logic idx_match(input logic [31:0] x, input logic [31:0] y,
                                     input int bits);
    logic [31:0] mask;
    mask = (32'(1) << bits) - 32'(1);
    return ((x ^ y) & mask) == 32'(0);
  endfunction

  // a configuration with 2^a ways hits when fewer conflicts than ways
  function automatic logic way_hit(input logic [CONF_W-1:0] conf, input int a);
    return int'(conf) < (1 << a);
  endfunction
endpackage

// File: rtl/sspa_stack.sv
module sspa_stack #(
  parameter int DEPTH = 16,
  parameter int BW    = 14,
  localparam int PW   = $clog2(DEPTH),
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [PW-1:0] rd_ptr,
  output logic [BW-1:0] rd_blk,
  output logic [FW-1:0] fill,
  input  logic          upd,
  input  logic          upd_found,
  input  logic [PW-1:0] upd_pos,
  input  logic [BW-1:0] upd_blk
);
  logic [BW-1:0] ent [DEPTH];

  assign rd_blk = ent[rd_ptr];

  always_ff @(posedge clk) begin
    if (upd) ent[0] <= upd_blk;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_ent
    // shift down every entry above the old copy (or all if none)
    always_ff @(posedge clk) begin
      if (upd && (!upd_found || PW'(i) <= upd_pos)) ent[i] <= ent[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   fill <= '0;
    else if (clr)                                 fill <= '0;
    else if (upd && !upd_found && fill != FW'(DEPTH)) fill <= fill + FW'(1);
  end

  p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));
  p_found_keeps_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd && upd_found && !clr |=> $stable(fill));
endmodule

// File: rtl/sspa_conflict.sv
module sspa_conflict
  import sspa_pkg::*;
#(
  parameter int K  = 3,
  parameter int BW = 14,
  localparam int NSC = K + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         step,
  input  logic [BW-1:0]                cur_blk,
  input  logic [BW-1:0]                ent_blk,
  output logic [NSC-1:0][CONF_W-1:0]   conf
);
  for (genvar s = 0; s < NSC; s++) begin : g_sc
    logic same_set;
    assign same_set = idx_match(32'(cur_blk), 32'(ent_blk), s);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      conf[s] <= '0;
      else if (start)  conf[s] <= '0;
      else if (step && same_set && conf[s] != CONF_W'(CONF_SAT))
        conf[s] <= conf[s] + CONF_W'(1);
    end

    p_conf_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      conf[s] <= CONF_W'(CONF_SAT));
  end
endmodule

// File: rtl/sspa_counters.sv
module sspa_counters #(
  parameter int NCFG = 12,
  parameter int CW   = 32,
  localparam int SW  = $clog2(NCFG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            inc,
  input  logic [NCFG-1:0] hit_vec,
  input  logic [SW-1:0]   rd_sel,
  output logic [CW-1:0]   rd_hits,
  output logic [CW-1:0]   rd_misses
);
  logic [CW-1:0] hits [NCFG];
  logic [CW-1:0] miss [NCFG];

  for (genvar c = 0; c < NCFG; c++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hits[c] <= '0;
        miss[c] <= '0;
      end else if (clr) begin
        hits[c] <= '0;
        miss[c] <= '0;
      end else if (inc) begin
        if (hit_vec[c]) hits[c] <= hits[c] + CW'(1);
        else            miss[c] <= miss[c] + CW'(1);
      end
    end
  end

  assign rd_hits   = (int'(rd_sel) < NCFG) ? hits[rd_sel] : '0;
  assign rd_misses = (int'(rd_sel) < NCFG) ? miss[rd_sel] : '0;

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !clr |=> (hits[0] + miss[0]) == $past(hits[0] + miss[0]) + CW'(1));
endmodule

// File: rtl/sspa_analyzer.sv
module sspa_analyzer
  import sspa_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 2,
  parameter int K      = 3,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 32,
  localparam int BW    = ADDR_W - OFF_W,
  localparam int NSC   = K + 1,
  localparam int NCFG  = NSC * NUM_ASSOC,
  localparam int SW    = $clog2(NCFG),
  localparam int PW    = $clog2(DEPTH),
  localparam int FW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              res_valid,
  output logic [NCFG-1:0]   res_hit,
  output logic              res_compulsory,
  output logic              res_dropped,
  input  logic [SW-1:0]     rd_sel,
  output logic [CNT_W-1:0]  rd_hits,
  output logic [CNT_W-1:0]  rd_misses
);
  st_t                       st;
  logic [FW-1:0]             ptr;
  logic [BW-1:0]             cur_blk;
  logic                      found;
  logic [PW-1:0]             pos;
  logic [BW-1:0]             ent_blk;
  logic [FW-1:0]             fill;
  logic [NSC-1:0][CONF_W-1:0] conf;
  logic [NCFG-1:0]           hit_vec;

  // named internal events
  logic accept, at_end, match, step, upd, drop;
  assign accept = (st == ST_IDLE) && in_valid && !clr;
  assign at_end = (ptr == fill);
  assign match  = (st == ST_SEARCH) && !at_end && (ent_blk == cur_blk);
  assign step   = (st == ST_SEARCH) && !at_end && !match;
  assign upd    = (st == ST_UPDATE) && !clr;
  assign drop   = !found && (fill == FW'(DEPTH));
  assign in_ready = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ptr <= '0; cur_blk <= '0; found <= 1'b0; pos <= '0;
    end else if (clr) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          st      <= ST_SEARCH;
          cur_blk <= in_addr[ADDR_W-1:OFF_W];
          ptr     <= '0;
          found   <= 1'b0;
        end
        ST_SEARCH: begin
          if (at_end) st <= ST_UPDATE;
          else if (match) begin
            st    <= ST_UPDATE;
            found <= 1'b1;
            pos   <= ptr[PW-1:0];
          end else ptr <= ptr + FW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  for (genvar s = 0; s < NSC; s++) begin : g_hs
    for (genvar a = 0; a < NUM_ASSOC; a++) begin : g_ha
      assign hit_vec[s*NUM_ASSOC + a] = found && way_hit(conf[s], a);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0; res_hit <= '0; res_compulsory <= 1'b0; res_dropped <= 1'b0;
    end else begin
      res_valid <= upd;
      if (upd) begin
        res_hit        <= hit_vec;
        res_compulsory <= !found;
        res_dropped    <= drop;
      end
    end
  end

  sspa_stack #(.DEPTH(DEPTH), .BW(BW)) u_stack (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .rd_ptr(ptr[PW-1:0]), .rd_blk(ent_blk), .fill(fill),
    .upd(upd), .upd_found(found), .upd_pos(pos), .upd_blk(cur_blk)
  );

  sspa_conflict #(.K(K), .BW(BW)) u_conf (
    .clk(clk), .rst_n(rst_n), .start(accept), .step(step),
    .cur_blk(cur_blk), .ent_blk(ent_blk), .conf(conf)
  );

  sspa_counters #(.NCFG(NCFG), .CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(upd), .hit_vec(hit_vec),
    .rd_sel(rd_sel), .rd_hits(rd_hits), .rd_misses(rd_misses)
  );

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  p_ready_after_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> in_ready);
  p_compulsory_nohit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_compulsory |-> res_hit == '0);
  p_drop_only_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_dropped |-> res_compulsory);

  for (genvar s = 0; s < NSC; s++) begin : g_ord
    for (genvar a = 0; a + 1 < NUM_ASSOC; a++) begin : g_oa
      p_assoc_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_hit[s*NUM_ASSOC + a] |-> res_hit[s*NUM_ASSOC + a + 1]);
    end
  end
endmodule

// File: tb/tb_sspa_analyzer.sv
module tb_sspa_analyzer;
  localparam int ADDR_W = 16, OFF_W = 2, K = 3, DEPTH = 16, CNT_W = 32;
  localparam int BW = ADDR_W - OFF_W, NSC = K + 1, NCFG = NSC * 3;
  localparam int SW = $clog2(NCFG);

  logic clk = 0, rst_n = 0, clr = 0, in_valid = 0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [SW-1:0] rd_sel = '0;
  logic in_ready, res_valid, res_compulsory, res_dropped;
  logic [NCFG-1:0] res_hit;
  logic [CNT_W-1:0] rd_hits, rd_misses;

  always #10 clk = ~clk;

  sspa_analyzer #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .K(K), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .res_valid(res_valid), .res_hit(res_hit),
    .res_compulsory(res_compulsory), .res_dropped(res_dropped),
    .rd_sel(rd_sel), .rd_hits(rd_hits), .rd_misses(rd_misses));

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [BW-1:0] mstk[$];
  int exp_h[NCFG], exp_m[NCFG];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    mstk.delete();
    for (int c = 0; c < NCFG; c++) begin exp_h[c] = 0; exp_m[c] = 0; end
  endtask

  // one access: drive, wait for result, compare with list model
  task automatic access(input logic [BW-1:0] b, input logic [OFF_W-1:0] off);
    int pos, lat, n0;
    int conf[NSC];
    logic [NCFG-1:0] eh;
    bit edrop;
    pos = -1;
    for (int s = 0; s < NSC; s++) conf[s] = 0;
    for (int i = 0; i < mstk.size(); i++) begin
      if (mstk[i] == b) begin pos = i; break; end
      for (int s = 0; s < NSC; s++)
        if ((int'(mstk[i]) % (1 << s)) == (int'(b) % (1 << s)) && conf[s] < 4) conf[s]++;
    end
    eh = '0;
    for (int s = 0; s < NSC; s++)
      for (int a = 0; a < 3; a++)
        eh[s*3+a] = (pos >= 0) && (conf[s] < (1 << a));
    n0 = mstk.size();
    edrop = (pos < 0) && (n0 == DEPTH);
    if (pos >= 0) mstk.delete(pos);
    mstk.push_front(b);
    if (mstk.size() > DEPTH) void'(mstk.pop_back());
    for (int c = 0; c < NCFG; c++) if (eh[c]) exp_h[c]++; else exp_m[c]++;

    @(negedge clk);
    in_valid = 1; in_addr = {b, off};
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk(in_ready == 0, "R7 busy after accept", in_ready, 0);
    lat = 0;
    while (!res_valid && lat < 200) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    chk(lat == ((pos >= 0) ? pos + 2 : n0 + 2), "R7 latency", lat, (pos >= 0) ? pos + 2 : n0 + 2);
    chk(res_hit == eh, "R4 hit vector", res_hit, eh);
    chk(res_compulsory == (pos < 0), "R2 compulsory flag", res_compulsory, pos < 0);
    chk(res_dropped == edrop, "R6 dropped flag", res_dropped, edrop);
    @(negedge clk);
    chk(in_ready == 1 && res_valid == 0, "R7 ready after result", {in_ready, res_valid}, 2'b10);
  endtask

  task automatic check_counters(input string tag);
    for (int c = 0; c < NCFG; c++) begin
      rd_sel = SW'(c); #1;
      chk(rd_hits == CNT_W'(exp_h[c]), {tag, " hits"}, rd_hits, exp_h[c]);
      chk(rd_misses == CNT_W'(exp_m[c]), {tag, " misses"}, rd_misses, exp_m[c]);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    model_clear();
  endtask

  task automatic t_reset();
    chk(in_ready == 1, "R7 reset ready", in_ready, 1);
    chk(res_valid == 0, "R7 reset no result", res_valid, 0);
    check_counters("R8 reset counters");
  endtask

  task automatic t_compulsory();
    access(14'd5, 2'd0); chk(res_compulsory == 1, "R2 first access", res_compulsory, 1);
    access(14'd6, 2'd1);
    access(14'd300, 2'd2);
    access(14'd6, 2'd0); // R5 repeat at top region
  endtask

  task automatic t_offset_r1();
    access(14'd40, 2'd0);
    access(14'd40, 2'd3);
    chk(res_hit == '1, "R1 offset ignored, R5 repeat hits all", res_hit, {NCFG{1'b1}});
  endtask

  task automatic t_conflicts_r3();
    do_clear();
    access(14'd1, 2'd0); access(14'd9, 2'd0); access(14'd17, 2'd0); access(14'd1, 2'd0);
    chk(res_hit == 12'h924, "R3 two same-set conflicts", res_hit, 12'h924);
    access(14'd2, 2'd0); access(14'd5, 2'd0); access(14'd2, 2'd0);
    chk(res_hit == 12'hFFE, "R3 conflict only with one set", res_hit, 12'hFFE);
  endtask

  task automatic t_saturate_r3();
    do_clear();
    access(14'd3, 2'd0);
    for (int i = 1; i <= 5; i++) access(14'(3 + 8*i), 2'd0);
    access(14'd3, 2'd0);
    chk(res_hit == '0 && res_compulsory == 0, "R3 saturated conflicts miss",
        {res_hit, res_compulsory}, 13'h0);
  endtask

  task automatic t_overflow_r6();
    do_clear();
    for (int i = 0; i < DEPTH; i++) access(14'(100 + i), 2'd0);
    chk(res_dropped == 0, "R6 full but no drop yet", res_dropped, 0);
    access(14'd200, 2'd0);
    chk(res_dropped == 1, "R6 drop on overflow", res_dropped, 1);
    access(14'd100, 2'd0);
    chk(res_compulsory == 1, "R6 discarded block compulsory", res_compulsory, 1);
    access(14'd110, 2'd0);
    check_counters("R8 after overflow");
  endtask

  task automatic t_clear_r9();
    access(14'd77, 2'd0);
    do_clear();
    chk(in_ready == 1, "R9 ready after clear", in_ready, 1);
    check_counters("R9 cleared counters");
    access(14'd77, 2'd0);
    chk(res_compulsory == 1, "R9 stack emptied", res_compulsory, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_compulsory();
    t_offset_r1();
    check_counters("R8 after mixed stream");
    t_conflicts_r3();
    t_saturate_r3();
    check_counters("R8 after saturation");
    t_overflow_r6();
    t_clear_r9();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule